// File: doc/BRIEF.md
# Instruction Prefetch Queue with Opcode Byte Select

This block holds program words fetched ahead of their use by a processor core. Two word-wide stages form the queue, and a holding latch sits in front of the first stage so that a fetch arriving while the first stage is busy is not lost. Every word travels with the address it was fetched from, so trace logic can rebuild, cycle by cycle, which opcode byte the core begins executing and where that byte lives in memory.

A 2-bit command input drives the queue. One code shifts the queue forward. Two codes begin an instruction from the second stage. Start-even takes the high-order byte of that stage. Start-odd takes the low-order byte. Either one reports the chosen byte and its byte address on the trace output one clock later. A start command issued while the second stage is empty raises an error pulse instead. A synchronous flush empties the queue, for example after a change of program flow.

Top module: `iq_prefetch`

## Requirements
- R1: After reset, `op_vld` and `op_err` are 0 and all stages and the latch are empty. A start command issued then produces an `op_err` pulse.
- R2: `cmd` encoding is 2'b00 no action, 2'b01 advance, 2'b10 start even, 2'b11 start odd. No action leaves the queue contents and the trace output registers unchanged, and `op_vld`/`op_err` read 0 on the following cycle.
- R3: A fetch (`fetch_vld`=1) with stage one empty and no advance loads stage one. An advance copies stage one (contents and valid flag) into stage two.
- R4: Start even with a valid stage two sets `op_vld`=1 one cycle later, with `op_byte` = bits [15:8] of the stage-two word and `op_addr` = its fetch address.
- R5: Start odd with a valid stage two sets `op_vld`=1 one cycle later, with `op_byte` = bits [7:0] of the stage-two word and `op_addr` = its fetch address plus 1.
- R6: A fetch while stage one is full, the latch is empty and no advance is requested is captured in the holding latch. On the next advance, stage one loads from the latch and the latch becomes empty.
- R7: When an advance and a fetch coincide and the latch is full, stage one takes the latch word and the latch takes the bus word. Program order is preserved.
- R8: When an advance and a fetch coincide and the latch is empty, the bus word goes straight into stage one.
- R9: A fetch while stage one and the latch are both full and no advance is requested is discarded.
- R10: A start command on an empty stage two gives `op_err`=1 and `op_vld`=0 one cycle later, and leaves `op_byte`/`op_addr` unchanged.
- R11: Start commands do not move the queue, so repeated starts read the same stage-two word.
- R12: `flush`=1 empties both stages and the latch. It overrides a fetch and a command in the same cycle and gives `op_vld`=`op_err`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of the queue and latch |
| fetch_vld | input | 1 | Fetched word present on `fetch_word` |
| fetch_word | input | WW (16) | Fetched program word |
| fetch_addr | input | AW (16) | Address of the fetched word (high byte) |
| cmd | input | 2 | Queue command (see R2) |
| op_vld | output | 1 | One-cycle pulse: opcode byte reported |
| op_byte | output | WW/2 (8) | Selected opcode byte |
| op_addr | output | AW (16) | Byte address of `op_byte` |
| op_err | output | 1 | One-cycle pulse: start on an empty stage two |

## Verification
The bound checker watches several relations on every cycle: an advance copies stage one into stage two, the holding latch is never full while stage one is empty, flush empties everything, and a start command yields either the correct byte and address or an error pulse on the next cycle. Some behaviour only shows up over a sequence of fetches and advances. That includes whether program order survives the latch refill when an advance and a fetch coincide, and whether a word that arrives with the queue full is truly discarded. The directed scenarios in the bench cover these by draining the queue through start commands and comparing each byte, address and error against a hand-derived order.

// File: rtl/iq_pkg.sv
package iq_pkg;

    localparam int IQ_WW = 16;
    localparam int IQ_AW = 16;

    typedef enum logic [1:0] {
        IQ_NOP  = 2'b00,
        IQ_ADV  = 2'b01,
        IQ_EVEN = 2'b10,
        IQ_ODD  = 2'b11
    } iq_cmd_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_HOLD = 2'b01,
        SRC_BUS  = 2'b10
    } iq_src_e;

endpackage

// File: rtl/iq_slot.sv
module iq_slot #(
    parameter int WW = iq_pkg::IQ_WW,
    parameter int AW = iq_pkg::IQ_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld,
    input  logic          d_vld,
    input  logic [WW-1:0] d_word,
    input  logic [AW-1:0] d_addr,
    output logic          q_vld,
    output logic [WW-1:0] q_word,
    output logic [AW-1:0] q_addr
);

    typedef struct packed {
        logic          vld;
        logic [WW-1:0] word;
        logic [AW-1:0] addr;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.vld = 1'b0;
        end else if (ld) begin
            st_d.vld  = d_vld;
            st_d.word = d_word;
            st_d.addr = d_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_vld  = st_q.vld;
    assign q_word = st_q.word;
    assign q_addr = st_q.addr;

endmodule

// File: rtl/iq_fill_ctrl.sv
module iq_fill_ctrl
    import iq_pkg::*;
(
    input  logic    adv,
    input  logic    fetch_vld,
    input  logic    s1_vld,
    input  logic    hl_vld,
    output logic    s1_ld,
    output iq_src_e s1_src,
    output logic    hl_ld,
    output logic    hl_dvld
);

    always_comb begin
        s1_ld   = 1'b0;
        s1_src  = SRC_NONE;
        hl_ld   = 1'b0;
        hl_dvld = 1'b0;
        if (adv) begin
            // stage one always refills on a shift; the latch is older than the bus
            s1_ld = 1'b1;
            if (hl_vld) begin
                s1_src  = SRC_HOLD;
                hl_ld   = 1'b1;
                hl_dvld = fetch_vld;
            end else if (fetch_vld) begin
                s1_src = SRC_BUS;
            end
        end else if (fetch_vld) begin
            if (!s1_vld) begin
                s1_ld  = 1'b1;
                s1_src = SRC_BUS;
            end else if (!hl_vld) begin
                hl_ld   = 1'b1;
                hl_dvld = 1'b1;
            end
            // both full: the word is discarded
        end
    end

endmodule

// File: rtl/iq_opsel.sv
module iq_opsel #(
    parameter int WW = iq_pkg::IQ_WW,
    parameter int AW = iq_pkg::IQ_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              start,
    input  logic              odd,
    input  logic              s2_vld,
    input  logic [WW-1:0]     s2_word,
    input  logic [AW-1:0]     s2_addr,
    output logic              op_vld,
    output logic [WW/2-1:0]   op_byte,
    output logic [AW-1:0]     op_addr,
    output logic              op_err
);

    localparam int BW = WW / 2;

    typedef struct packed {
        logic          vld;
        logic          err;
        logic [BW-1:0] byte_v;
        logic [AW-1:0] addr;
    } op_t;

    op_t op_d, op_q;
    logic [BW-1:0] hi_byte, lo_byte;

    assign hi_byte = s2_word[WW-1 -: BW];
    assign lo_byte = s2_word[BW-1:0];

    always_comb begin
        op_d     = op_q;
        op_d.vld = 1'b0;
        op_d.err = 1'b0;
        if (!flush && start) begin
            if (s2_vld) begin
                op_d.vld    = 1'b1;
                op_d.byte_v = odd ? lo_byte : hi_byte;
                op_d.addr   = odd ? s2_addr + AW'(1) : s2_addr;
            end else begin
                op_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) op_q <= '0;
        else        op_q <= op_d;
    end

    assign op_vld  = op_q.vld;
    assign op_err  = op_q.err;
    assign op_byte = op_q.byte_v;
    assign op_addr = op_q.addr;

endmodule

// File: rtl/iq_prefetch.sv
module iq_prefetch
    import iq_pkg::*;
#(
    parameter int WW = IQ_WW,
    parameter int AW = IQ_AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            fetch_vld,
    input  logic [WW-1:0]   fetch_word,
    input  logic [AW-1:0]   fetch_addr,
    input  logic [1:0]      cmd,
    output logic            op_vld,
    output logic [WW/2-1:0] op_byte,
    output logic [AW-1:0]   op_addr,
    output logic            op_err
);

    iq_cmd_e cmd_e;
    logic    adv, start, odd;

    assign cmd_e = iq_cmd_e'(cmd);
    assign adv   = (cmd_e == IQ_ADV);
    assign start = (cmd_e == IQ_EVEN) || (cmd_e == IQ_ODD);
    assign odd   = (cmd_e == IQ_ODD);

    logic          s1_vld, s2_vld, hl_vld;
    logic [WW-1:0] s1_word, s2_word, hl_word;
    logic [AW-1:0] s1_addr, s2_addr, hl_addr;

    logic          s1_ld, hl_ld, hl_dvld;
    iq_src_e       s1_src;
    logic          s1_dvld;
    logic [WW-1:0] s1_dword;
    logic [AW-1:0] s1_daddr;

    iq_fill_ctrl u_ctrl (
        .adv       (adv),
        .fetch_vld (fetch_vld),
        .s1_vld    (s1_vld),
        .hl_vld    (hl_vld),
        .s1_ld     (s1_ld),
        .s1_src    (s1_src),
        .hl_ld     (hl_ld),
        .hl_dvld   (hl_dvld)
    );

    always_comb begin
        s1_dvld  = 1'b0;
        s1_dword = fetch_word;
        s1_daddr = fetch_addr;
        case (s1_src)
            SRC_HOLD: begin
                s1_dvld  = 1'b1;
                s1_dword = hl_word;
                s1_daddr = hl_addr;
            end
            SRC_BUS:  s1_dvld = 1'b1;
            default:  s1_dvld = 1'b0;
        endcase
    end

    iq_slot #(.WW(WW), .AW(AW)) u_hold (
        .clk(clk), .rst_n(rst_n), .clr(flush), .ld(hl_ld),
        .d_vld(hl_dvld), .d_word(fetch_word), .d_addr(fetch_addr),
        .q_vld(hl_vld), .q_word(hl_word), .q_addr(hl_addr)
    );

    iq_slot #(.WW(WW), .AW(AW)) u_stage1 (
        .clk(clk), .rst_n(rst_n), .clr(flush), .ld(s1_ld),
        .d_vld(s1_dvld), .d_word(s1_dword), .d_addr(s1_daddr),
        .q_vld(s1_vld), .q_word(s1_word), .q_addr(s1_addr)
    );

    iq_slot #(.WW(WW), .AW(AW)) u_stage2 (
        .clk(clk), .rst_n(rst_n), .clr(flush), .ld(adv),
        .d_vld(s1_vld), .d_word(s1_word), .d_addr(s1_addr),
        .q_vld(s2_vld), .q_word(s2_word), .q_addr(s2_addr)
    );

    iq_opsel #(.WW(WW), .AW(AW)) u_opsel (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .start(start), .odd(odd),
        .s2_vld(s2_vld), .s2_word(s2_word), .s2_addr(s2_addr),
        .op_vld(op_vld), .op_byte(op_byte), .op_addr(op_addr), .op_err(op_err)
    );

endmodule

// File: rtl/iq_prefetch_chk.sv
module iq_prefetch_chk #(
    parameter int WW = 16,
    parameter int AW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush,
    input logic [1:0]      cmd,
    input logic            s1_vld,
    input logic [WW-1:0]   s1_word,
    input logic [AW-1:0]   s1_addr,
    input logic            s2_vld,
    input logic [WW-1:0]   s2_word,
    input logic [AW-1:0]   s2_addr,
    input logic            hl_vld,
    input logic            op_vld,
    input logic [WW/2-1:0] op_byte,
    input logic [AW-1:0]   op_addr,
    input logic            op_err
);

    p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b01 && !flush) |=> (s2_vld == $past(s1_vld)) &&
            (!s2_vld || (s2_word == $past(s1_word) && s2_addr == $past(s1_addr))));

    p_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b10 && !flush && s2_vld) |=> op_vld && !op_err &&
            op_byte == $past(s2_word[WW-1 -: WW/2]) && op_addr == $past(s2_addr));

    p_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b11 && !flush && s2_vld) |=> op_vld && !op_err &&
            op_byte == $past(s2_word[WW/2-1:0]) && op_addr == $past(s2_addr) + AW'(1));

    p_latch_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hl_vld |-> s1_vld);

    p_empty_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd[1] && !flush && !s2_vld) |=> op_err && !op_vld && $stable(op_byte) && $stable(op_addr));

    p_start_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd[1] && !flush) |=> $stable(s2_vld) && $stable(s2_word) && $stable(s2_addr));

    p_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !s1_vld && !s2_vld && !hl_vld && !op_vld && !op_err);

    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_vld && op_err));

endmodule

bind iq_prefetch iq_prefetch_chk #(.WW(WW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cmd(cmd),
    .s1_vld(s1_vld), .s1_word(s1_word), .s1_addr(s1_addr),
    .s2_vld(s2_vld), .s2_word(s2_word), .s2_addr(s2_addr),
    .hl_vld(hl_vld),
    .op_vld(op_vld), .op_byte(op_byte), .op_addr(op_addr), .op_err(op_err)
);

// File: tb/iq_prefetch_test.sv
module iq_prefetch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        fetch_vld = 1'b0;
    logic [15:0] fetch_word = '0;
    logic [15:0] fetch_addr = '0;
    logic [1:0]  cmd = 2'b00;
    logic        op_vld, op_err;
    logic [7:0]  op_byte;
    logic [15:0] op_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [1:0] NOP = 2'b00, ADV = 2'b01, EVN = 2'b10, ODD = 2'b11;

    always #4 clk = ~clk;

    iq_prefetch uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fetch_vld(fetch_vld), .fetch_word(fetch_word), .fetch_addr(fetch_addr),
        .cmd(cmd),
        .op_vld(op_vld), .op_byte(op_byte), .op_addr(op_addr), .op_err(op_err)
    );

    task automatic step(input logic [1:0] c, input logic fv,
                        input logic [15:0] w, input logic [15:0] a, input logic fl);
        cmd = c; fetch_vld = fv; fetch_word = w; fetch_addr = a; flush = fl;
        @(posedge clk); #1;
        cmd = NOP; fetch_vld = 1'b0; flush = 1'b0;
    endtask

    task automatic chk_op(input string req, input logic ev, input logic ee,
                          input logic [7:0] eb, input logic [15:0] ea);
        checks++;
        if (op_vld !== ev || op_err !== ee || (ev && (op_byte !== eb || op_addr !== ea))) begin
            errors++;
            $display("FAIL %s: got vld=%0b err=%0b byte=%h addr=%h, expected vld=%0b err=%0b byte=%h addr=%h",
                     req, op_vld, op_err, op_byte, op_addr, ev, ee, eb, ea);
        end
    endtask

    task automatic chk_hold(input string req, input logic [7:0] eb, input logic [15:0] ea);
        checks++;
        if (op_vld !== 1'b0 || op_byte !== eb || op_addr !== ea) begin
            errors++;
            $display("FAIL %s: got vld=%0b byte=%h addr=%h, expected vld=0 byte=%h addr=%h",
                     req, op_vld, op_byte, op_addr, eb, ea);
        end
    endtask

    task automatic t_reset;
        chk_op("R1 reset outputs", 1'b0, 1'b0, 8'h00, 16'h0);
        step(EVN, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_op("R1 start after reset errs", 1'b0, 1'b1, 8'h00, 16'h0);
    endtask

    task automatic t_basic;
        step(NOP, 1'b0, 16'h0, 16'h0, 1'b1);
        step(NOP, 1'b1, 16'h1234, 16'h0100, 1'b0);
        step(ADV, 1'b0, 16'h0, 16'h0, 1'b0);
        step(EVN, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_op("R3 R4 even byte", 1'b1, 1'b0, 8'h12, 16'h0100);
        step(ODD, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_op("R5 R11 odd byte same word", 1'b1, 1'b0, 8'h34, 16'h0101);
        step(NOP, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_hold("R2 nop pulse ends", 8'h34, 16'h0101);
        step(EVN, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_op("R2 R11 queue kept over nop", 1'b1, 1'b0, 8'h12, 16'h0100);
    endtask

    task automatic t_latch_drop;
        step(NOP, 1'b0, 16'h0, 16'h0, 1'b1);
        step(NOP, 1'b1, 16'hA1A2, 16'h0200, 1'b0);
        step(NOP, 1'b1, 16'hB1B2, 16'h0202, 1'b0);
        step(NOP, 1'b1, 16'hC1C2, 16'h0204, 1'b0);
        step(ADV, 1'b0, 16'h0, 16'h0, 1'b0);
        step(EVN, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_op("R6 first word", 1'b1, 1'b0, 8'hA1, 16'h0200);
        step(ADV, 1'b0, 16'h0, 16'h0, 1'b0);
        step(ODD, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_op("R6 latch word next", 1'b1, 1'b0, 8'hB2, 16'h0203);
        step(ADV, 1'b0, 16'h0, 16'h0, 1'b0);
        step(EVN, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_op("R9 R10 third fetch dropped", 1'b0, 1'b1, 8'h00, 16'h0);
        checks++;
        if (op_byte !== 8'hB2 || op_addr !== 16'h0203) begin
            errors++;
            $display("FAIL R10 error keeps trace: got byte=%h addr=%h, expected byte=b2 addr=0203",
                     op_byte, op_addr);
        end
        step(NOP, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_op("R2 error pulse ends", 1'b0, 1'b0, 8'h00, 16'h0);
    endtask

    task automatic t_refill;
        step(NOP, 1'b0, 16'h0, 16'h0, 1'b1);
        step(NOP, 1'b1, 16'h1111, 16'h0300, 1'b0);
        step(NOP, 1'b1, 16'h2222, 16'h0302, 1'b0);
        step(ADV, 1'b1, 16'h3333, 16'h0304, 1'b0);
        step(EVN, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_op("R7 head word", 1'b1, 1'b0, 8'h11, 16'h0300);
        step(ADV, 1'b0, 16'h0, 16'h0, 1'b0);
        step(EVN, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_op("R7 latch word second", 1'b1, 1'b0, 8'h22, 16'h0302);
        step(ADV, 1'b0, 16'h0, 16'h0, 1'b0);
        step(ODD, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_op("R7 refilled bus word third", 1'b1, 1'b0, 8'h33, 16'h0305);
    endtask

    task automatic t_direct;
        step(NOP, 1'b0, 16'h0, 16'h0, 1'b1);
        step(NOP, 1'b1, 16'h4455, 16'h0400, 1'b0);
        step(ADV, 1'b1, 16'h6677, 16'h0402, 1'b0);
        step(ODD, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_op("R8 head word", 1'b1, 1'b0, 8'h55, 16'h0401);
        step(ADV, 1'b0, 16'h0, 16'h0, 1'b0);
        step(EVN, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_op("R8 bus word in stage one", 1'b1, 1'b0, 8'h66, 16'h0402);
        step(ADV, 1'b0, 16'h0, 16'h0, 1'b0);
        step(EVN, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_op("R8 nothing held in latch", 1'b0, 1'b1, 8'h00, 16'h0);
    endtask

    task automatic t_flush;
        step(NOP, 1'b1, 16'h8899, 16'h0500, 1'b0);
        step(ADV, 1'b1, 16'hAABB, 16'h0502, 1'b0);
        step(NOP, 1'b1, 16'hCCDD, 16'h0504, 1'b0);
        step(EVN, 1'b1, 16'hEEFF, 16'h0506, 1'b1);
        chk_op("R12 flush beats start", 1'b0, 1'b0, 8'h00, 16'h0);
        step(EVN, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_op("R12 stage two empty", 1'b0, 1'b1, 8'h00, 16'h0);
        step(ADV, 1'b0, 16'h0, 16'h0, 1'b0);
        step(EVN, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_op("R12 stage one and fetch cleared", 1'b0, 1'b1, 8'h00, 16'h0);
        step(ADV, 1'b0, 16'h0, 16'h0, 1'b0);
        step(EVN, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_op("R12 latch cleared", 1'b0, 1'b1, 8'h00, 16'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_latch_drop();
        t_refill();
        t_direct();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule